// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer events into a byte stream for a serial mouse link. Each event carries a horizontal and a vertical motion delta, both 16-bit signed, and the state of three buttons. It is offered on a valid/ready strobe. An accepted event becomes a five-byte packet, and the packet is written into a byte queue. The consumer reads the queue one byte per strobe. A data-available flag tells the consumer when bytes are waiting.

The packet is built as follows. A header byte carries the buttons active-low. The horizontal delta is clamped symmetrically to the range −127 to +127. The vertical delta is negated first and then clamped to the same range. Two zero bytes close the packet. A packet is only accepted when there is room for the whole of it, so the queue never holds part of a packet.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of a packet is 0x87 XOR-ed with 0x04 when the left button is pressed, 0x02 when the middle button is pressed and 0x01 when the right button is pressed.
- R2: The second byte is the horizontal delta, clamped to the range −127..+127, as 8-bit two's complement. For example, +300 gives 0x7F, and both −300 and −32768 give 0x81.
- R3: The third byte is the negated vertical delta, clamped to the range −127..+127, as 8-bit two's complement. For example, +2 gives 0xFE, and −32768 gives 0x7F.
- R4: The fourth and fifth bytes are always 0x00.
- R5: After an event is accepted, its five bytes enter the queue in order, one per clock. The first byte enters on the clock that follows the accepting clock.
- R6: `evt_ready` is high only when no packet is still being written and at least five queue entries are free. While it is low, `evt_valid` has no effect. After 51 packets with no reads, 255 bytes are queued and further events are refused.
- R7: The queue holds up to 256 bytes and returns them in first-in, first-out order. A byte that arrives while the queue is full is dropped.
- R8: While the queue is empty, `rd_data` reads 0x00. A read strobe on an empty queue changes nothing.
- R9: `data_avail` is high exactly while the queue holds at least one byte. It stays high after a read as long as bytes remain.
- R10: A read and a packet byte entering the queue in the same clock both take effect.
- R11: After reset the queue is empty, `data_avail` is low, `rd_data` is 0x00 and `evt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be accepted this cycle |
| dx | input | 16 | Horizontal motion delta, signed |
| dy | input | 16 | Vertical motion delta, signed |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| rd_en | input | 1 | Read strobe, pops one byte |
| rd_data | output | 8 | Byte at the queue head (0x00 when empty) |
| data_avail | output | 1 | Queue holds at least one byte |

## Verification
Two operations can fall in the same clock: the loader writing one packet byte, and the consumer popping the head of the queue. The bench provokes this by holding the read strobe high for the whole time a packet is being written. Each byte is then popped one cycle after it enters the queue, while the next byte is being written. The reference model applies the pop and then the write within a single modelled edge. It compares the head byte, the data-available flag and the ready flag on every cycle. At the end, an empty queue confirms that no byte was lost or counted twice.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN   = 5;
  localparam int MAG       = 127;
  localparam logic [7:0] HEAD_BASE = 8'h87;

  // Symmetric saturation to +/-MAG, result as 8-bit two's complement.
  function automatic logic [7:0] clamp_byte(input int v);
    int c;
    c = v;
    if (c > MAG) c = MAG;
    else if (c < -MAG) c = -MAG;
    return c[7:0];
  endfunction

  // Buttons are active-low in the header: a press clears its bit.
  function automatic logic [7:0] head_byte(input logic l, input logic m, input logic r);
    return HEAD_BASE ^ {5'b00000, l, m, r};
  endfunction
endpackage

// File: rtl/mpe_fmt.sv
module mpe_fmt
  import mpe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]             dx,
  input  logic [DW-1:0]             dy,
  input  logic [2:0]                btn,   // {left, mid, right}
  output logic [PKT_LEN-1:0][7:0]   pkt
);
  logic signed [DW-1:0] dx_s, dy_s;
  int x_val, y_neg;

  assign dx_s = dx;
  assign dy_s = dy;

  always_comb begin
    x_val  = int'(dx_s);
    y_neg  = -int'(dy_s);
    pkt[0] = head_byte(btn[2], btn[1], btn[0]);
    pkt[1] = clamp_byte(x_val);
    pkt[2] = clamp_byte(y_neg);
  end

  for (genvar g = 3; g < PKT_LEN; g++) begin : g_pad
    assign pkt[g] = 8'h00;
  end
endmodule

// File: rtl/mpe_loader.sv
module mpe_loader
  import mpe_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic                    room_ok,
  input  logic [PKT_LEN-1:0][7:0] pkt,
  output logic                    evt_ready,
  output logic                    accept,
  output logic                    push,
  output logic [7:0]              push_data
);
  localparam int CW = $clog2(PKT_LEN + 1);

  logic [PKT_LEN-1:0][7:0] sh;
  logic [CW-1:0]           left;

  assign evt_ready = (left == '0) && room_ok;
  assign accept    = evt_valid && evt_ready;
  assign push      = (left != '0);
  assign push_data = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (accept) begin
      sh   <= pkt;
      left <= CW'(PKT_LEN);
    end else if (left != '0) begin
      sh   <= {8'h00, sh[PKT_LEN-1:1]};
      left <= left - 1'b1;
    end
  end

  // R6: once a packet is taken, no second one is taken next cycle
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !evt_ready);
  // R5: the first byte goes out on the clock after acceptance
  a_r5_push_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> push);
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  output logic [7:0]    rdata,
  output logic [CW-1:0] level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          pop_ok, push_ok, nonempty;

  assign nonempty = (level != '0);
  assign pop_ok   = pop && nonempty;
  assign push_ok  = push && ((level < CW'(DEPTH)) || pop_ok);
  assign rdata    = nonempty ? mem[rd_ptr] : 8'h00;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R10: a simultaneous write and pop leave the fill level unchanged
  a_r10_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && nonempty) |=> (level == $past(level)));
  // R7: a write into a full queue without a pop is dropped
  a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && push && !pop) |=> (level == CW'(DEPTH)));
  // R8: a pop on an empty queue changes nothing
  a_r8_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !nonempty && !push) |=> (level == '0));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [DW-1:0] dx,
  input  logic [DW-1:0] dy,
  input  logic          btn_left,
  input  logic          btn_mid,
  input  logic          btn_right,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          data_avail
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [PKT_LEN-1:0][7:0] pkt;
  logic [CW-1:0]           level;
  logic                    room_ok, accept, push;
  logic [7:0]              push_data;

  assign room_ok    = (CW'(DEPTH) - level) >= CW'(PKT_LEN);
  assign data_avail = (level != '0);

  mpe_fmt #(.DW(DW)) u_fmt (
    .dx  (dx),
    .dy  (dy),
    .btn ({btn_left, btn_mid, btn_right}),
    .pkt (pkt)
  );

  mpe_loader u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .room_ok   (room_ok),
    .pkt       (pkt),
    .evt_ready (evt_ready),
    .accept    (accept),
    .push      (push),
    .push_data (push_data)
  );

  mpe_fifo #(.DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (push_data),
    .pop   (rd_en),
    .rdata (rd_data),
    .level (level)
  );

  // R9: a byte written into the queue makes data available next cycle
  a_r9_avail_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data_avail);
  // R8: with nothing queued the read port shows zero
  a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> (rd_data == 8'h00));
endmodule

// File: tb/mouse_pkt_enc_tb_top.sv
module mouse_pkt_enc_tb_top;
  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, btn_left = 0, btn_mid = 0, btn_right = 0, rd_en = 0;
  logic [15:0] dx = 0, dy = 0;
  logic evt_ready, data_avail;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit  model_on = 0;
  string tag = "R11";

  always #5 clk = ~clk;

  mouse_pkt_enc dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .dx(dx), .dy(dy), .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
    .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail)
  );

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  logic [7:0] pq[$];

  function automatic logic [7:0] sat(input int v);
    int t;
    t = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return t[7:0];
  endfunction

  function automatic bit m_ready();
    return (pq.size() == 0) && (256 - mq.size() >= 5);
  endfunction

  always @(posedge clk) begin : model
    bit acc;
    logic [7:0] b0;
    if (!rst_n) begin
      mq.delete();
      pq.delete();
    end else begin
      acc = evt_valid && m_ready();
      if (rd_en && mq.size() > 0) void'(mq.pop_front());
      if (pq.size() > 0) begin
        if (mq.size() < 256) mq.push_back(pq.pop_front());
        else void'(pq.pop_front());
      end
      if (acc) begin
        b0 = 8'h87;
        if (btn_left)  b0 = b0 ^ 8'h04;
        if (btn_mid)   b0 = b0 ^ 8'h02;
        if (btn_right) b0 = b0 ^ 8'h01;
        pq.push_back(b0);
        pq.push_back(sat(int'($signed(dx))));
        pq.push_back(sat(-int'($signed(dy))));
        pq.push_back(8'h00);
        pq.push_back(8'h00);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(tag,  {24'h0, rd_data}, {24'h0, (mq.size() > 0) ? mq[0] : 8'h00});
      chk("R9", {31'h0, data_avail}, {31'h0, mq.size() > 0});
      chk("R6", {31'h0, evt_ready}, {31'h0, m_ready()});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int x, input int y, input bit l, input bit m, input bit r);
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    dx = x[15:0]; dy = y[15:0];
    btn_left = l; btn_mid = m; btn_right = r;
    evt_valid = 1;
    @(negedge clk);
    evt_valid = 0;
  endtask

  // Called at a negedge: check head, pop it, return at the next negedge.
  task automatic rd_expect(input logic [7:0] exp, input string req);
    chk(req, {24'h0, rd_data}, {24'h0, exp});
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11", {24'h0, rd_data}, 32'h0);
    chk("R11", {31'h0, data_avail}, 32'h0);
    chk("R11", {31'h0, evt_ready}, 32'h1);
    model_on = 1;

    // R1..R4: left button, small deltas
    tag = "R1";
    send(3, 2, 1, 0, 0);
    repeat (6) @(negedge clk);
    chk("R9", {31'h0, data_avail}, 32'h1);
    rd_expect(8'h83, "R1");
    chk("R9", {31'h0, data_avail}, 32'h1);
    rd_expect(8'h03, "R2");
    rd_expect(8'hFE, "R3");
    rd_expect(8'h00, "R4");
    rd_expect(8'h00, "R4");
    chk("R9", {31'h0, data_avail}, 32'h0);

    // R2/R3 saturation, middle+right buttons
    tag = "R2";
    send(300, -300, 0, 1, 1);
    repeat (6) @(negedge clk);
    rd_expect(8'h84, "R1");
    rd_expect(8'h7F, "R2");
    rd_expect(8'h7F, "R3");
    rd_expect(8'h00, "R4");
    rd_expect(8'h00, "R4");

    // R5/R7: two packets back to back, FIFO order; extreme values
    tag = "R7";
    send(-32768, -32768, 0, 0, 0);
    send(-127, 127, 1, 1, 1);
    repeat (6) @(negedge clk);
    rd_expect(8'h87, "R1");
    rd_expect(8'h81, "R2");
    rd_expect(8'h7F, "R3");
    rd_expect(8'h00, "R4");
    rd_expect(8'h00, "R4");
    rd_expect(8'h80, "R7");
    rd_expect(8'h81, "R7");
    rd_expect(8'h81, "R3");
    rd_expect(8'h00, "R7");
    rd_expect(8'h00, "R7");

    // R8: reading an empty queue
    tag = "R8";
    rd_expect(8'h00, "R8");
    rd_expect(8'h00, "R8");
    chk("R8", {31'h0, data_avail}, 32'h0);
    chk("R8", {31'h0, evt_ready}, 32'h1);

    // R5: first byte appears one clock after acceptance
    tag = "R5";
    @(negedge clk);
    dx = 16'd5; dy = 16'd0; btn_left = 0; btn_mid = 0; btn_right = 1;
    evt_valid = 1;
    @(negedge clk);
    evt_valid = 0;
    chk("R5", {31'h0, data_avail}, 32'h0);
    @(negedge clk);
    chk("R5", {31'h0, data_avail}, 32'h1);
    chk("R5", {24'h0, rd_data}, 32'h86);
    repeat (5) @(negedge clk);
    rd_expect(8'h86, "R5");
    rd_expect(8'h05, "R5");
    rd_expect(8'h00, "R5");
    rd_expect(8'h00, "R5");
    rd_expect(8'h00, "R5");

    // R10: reads held high while a packet is written
    tag = "R10";
    rd_en = 1;
    send(-1, 1, 1, 0, 1);
    repeat (8) @(negedge clk);
    rd_en = 0;
    chk("R10", {31'h0, data_avail}, 32'h0);

    // R6: fill without reading
    tag = "R6";
    for (int i = 0; i < 51; i++) send(i, -i, i[0], i[1], i[2]);
    repeat (6) @(negedge clk);
    chk("R6", {31'h0, evt_ready}, 32'h0);
    dx = 16'd9; dy = 16'd9; evt_valid = 1;
    repeat (10) @(negedge clk);
    chk("R6", {31'h0, evt_ready}, 32'h0);
    evt_valid = 0;
    begin
      int n;
      n = 0;
      while (data_avail) begin
        rd_en = 1;
        @(negedge clk);
        n++;
      end
      rd_en = 0;
      chk("R6", n, 255);
    end
    chk("R9", {31'h0, data_avail}, 32'h0);
    chk("R6", {31'h0, evt_ready}, 32'h1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule